// File: doc/BRIEF.md
# Tick Compare Timer with Disable Flags

This block holds a free-running 63-bit tick counter and two 64-bit compare registers, one for the supervisor and one for the hypervisor. A write to a compare register arms it, provided the value is ahead of the count. When the counter reaches an armed compare value, the block emits a one-cycle match pulse for that comparator.

The top bit of each compare register is an interrupt-disable flag. The low 63 bits are the match value. A supervisor match with the flag clear sets the system-tick bit (bit 16) of a 17-bit soft interrupt register. A hypervisor match with the flag clear sets a one-bit hypervisor interrupt-pending flag, but only while the strand is not halted.

Software reaches the counter, both compare registers, the soft interrupt register and the pending flag through one write port and one combinational read port. The soft interrupt register is written directly, set bitwise or cleared bitwise. Interrupt delivery beyond setting these bits is left to the surrounding logic.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the count is 0 and both compare registers read 0x8000_0000_0000_0000 (disabled, value 0). The soft interrupt register, the pending flag and both pulses are 0.
- R2: The count increases by one at each clock edge where tick_en is 1, holds when tick_en is 0, and wraps from 2^63-1 to 0. A write with wr_sel=0 loads wr_data[62:0] instead and takes priority over counting.
- R3: A write to a compare register (wr_sel=1 supervisor, wr_sel=2 hypervisor) arms it only if wr_data[62:0] is greater than the count in the write cycle. An armed comparator whose value equals the count raises its pulse for exactly one cycle, in the next cycle, and is then disarmed.
- R4: Only bits 62:0 of a compare register take part in matching. A read returns all 64 written bits.
- R5: When bit 63 of a compare register is 1, its match still pulses but sets no interrupt bit.
- R6: A supervisor match with bit 63 clear sets softint[16] in the same cycle the pulse appears, and leaves the other bits unchanged.
- R7: A hypervisor match with bit 63 clear sets hintp to 1, unless halted was 1 in the cycle of the match.
- R8: Writing a compare register in the cycle its old value would match suppresses that match. The old value never matches again.
- R9: wr_sel=3 writes softint from wr_data[16:0], wr_sel=4 sets the bits that are 1 in wr_data, wr_sel=5 clears them, and wr_sel=6 writes hintp from wr_data[0]. A same-cycle match set takes precedence over these writes.
- R10: rd_data is combinational from rd_sel. The encodings are: 0 gives {0,count}, 1 the supervisor compare, 2 the hypervisor compare, 3 zero-extended softint, and 6 zero-extended hintp. Any other value reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counter advance enable |
| halted | input | 1 | Strand halted; blocks hypervisor interrupt |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write register select |
| wr_data | input | 64 | Write data |
| rd_sel | input | 3 | Read register select |
| rd_data | output | 64 | Read data |
| sup_pulse | output | 1 | Supervisor match pulse |
| hyp_pulse | output | 1 | Hypervisor match pulse |
| softint | output | 17 | Soft interrupt register |
| hintp | output | 1 | Hypervisor interrupt pending |

## Verification
The bench targets these corner cases:
- **Compare equal to the count.** A design that armed on "greater or equal" would pulse at once.
- **Rewrite in the match cycle.** A design that let the old value win would pulse after the compare value was replaced.
- **Counter stalled on an equal value.** A comparator that was not disarmed after its match would pulse on every cycle.
- **Counter wrap.** The count must roll over correctly from its maximum to 0.
- **Disable flag and halted strand.** A design that ignored either would raise an interrupt bit where none is due.
- **Soft interrupt clear in the same cycle as a supervisor match.** A design that let the clear win would lose the tick bit.

// File: rtl/tct_pkg.sv
// Shared register-select encoding for the tick compare timer.
package tct_pkg;
    typedef enum logic [2:0] {
        SEL_COUNT   = 3'd0,
        SEL_SUPCMP  = 3'd1,
        SEL_HYPCMP  = 3'd2,
        SEL_SOFT    = 3'd3,
        SEL_SOFTSET = 3'd4,
        SEL_SOFTCLR = 3'd5,
        SEL_HINT    = 3'd6
    } reg_sel_t;
endpackage

// File: rtl/tct_counter.sv
// Free-running tick counter.
// Counts up by one when enabled and wraps at its width.
// A load overrides counting. Assumes a synchronous active-low reset.
module tct_counter #(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);
    // Advance, load or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (tick_en)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/tct_comparator.sv
// One compare register with an arm flag.
// A write stores the full value; its top bit is the disable flag.
// The write arms the comparator only when the value lies ahead of the count.
// A match fires once, then disarms. A write in the match cycle cancels the match.
module tct_comparator #(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W:0]   wr_val,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W:0]   cmp_q,
    output logic             hit,
    output logic             pulse
);
    logic armed;

    // Combinational match against the current count.
    always_comb hit = armed && (count == cmp_q[CNT_W-1:0]) && !wr;

    // Hold the compare value and the arm state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= {1'b1, {CNT_W{1'b0}}};
            armed <= 1'b0;
        end else if (wr) begin
            cmp_q <= wr_val;
            armed <= (wr_val[CNT_W-1:0] > count);
        end else if (hit) begin
            armed <= 1'b0;
        end
    end

    // Register the one-cycle match pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= hit;
    end
endmodule

// File: rtl/tct_intr_regs.sv
// Soft interrupt register and hypervisor pending flag.
// Software can write, set or clear the soft interrupt bits.
// A same-cycle set from a match wins over software access.
module tct_intr_regs #(
    parameter int SOFT_W   = 17,
    parameter int TICK_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_wr,
    input  logic              soft_set,
    input  logic              soft_clr,
    input  logic [SOFT_W-1:0] soft_val,
    input  logic              hint_wr,
    input  logic              hint_val,
    input  logic              tick_set,
    input  logic              hyp_set,
    output logic [SOFT_W-1:0] softint,
    output logic              hintp
);
    logic [SOFT_W-1:0] soft_next;

    // Apply software access, then the match set.
    always_comb begin
        soft_next = softint;
        if (soft_wr)       soft_next = soft_val;
        else if (soft_set) soft_next = softint | soft_val;
        else if (soft_clr) soft_next = softint & ~soft_val;
        if (tick_set)      soft_next[TICK_BIT] = 1'b1;
    end

    // Store the soft interrupt bits.
    always_ff @(posedge clk) begin
        if (!rst_n) softint <= '0;
        else        softint <= soft_next;
    end

    // Store the hypervisor pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       hintp <= 1'b0;
        else if (hyp_set) hintp <= 1'b1;
        else if (hint_wr) hintp <= hint_val;
    end
endmodule

// File: rtl/tick_cmp_timer.sv
// Tick compare timer top.
// Contains a 63-bit counter, two compare registers and the interrupt bits
// they set. Decodes the write port and muxes the read port.
// Assumes a synchronous active-low reset.
module tick_cmp_timer #(
    parameter int CNT_W    = 63,
    parameter int SOFT_W   = 17,
    parameter int TICK_BIT = 16,
    parameter int SEL_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              halted,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [CNT_W:0]    wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [CNT_W:0]    rd_data,
    output logic              sup_pulse,
    output logic              hyp_pulse,
    output logic [SOFT_W-1:0] softint,
    output logic              hintp
);
    import tct_pkg::*;

    localparam int DW     = CNT_W + 1;
    localparam int N_CMP  = 2;

    logic [CNT_W-1:0] count_q;
    logic [DW-1:0]    cmp_q   [N_CMP];
    logic [N_CMP-1:0] cmp_wr;
    logic [N_CMP-1:0] hit;
    logic [N_CMP-1:0] pulse;
    logic [DW-1:0]    sup_cmp_q;
    logic [DW-1:0]    hyp_cmp_q;

    // Decode compare-register writes.
    always_comb begin
        cmp_wr[0] = wr_en && (wr_sel == SEL_SUPCMP);
        cmp_wr[1] = wr_en && (wr_sel == SEL_HYPCMP);
    end

    tct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load     (wr_en && (wr_sel == SEL_COUNT)),
        .load_val (wr_data[CNT_W-1:0]),
        .count    (count_q)
    );

    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
        tct_comparator #(.CNT_W(CNT_W)) u_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (cmp_wr[i]),
            .wr_val (wr_data),
            .count  (count_q),
            .cmp_q  (cmp_q[i]),
            .hit    (hit[i]),
            .pulse  (pulse[i])
        );
    end

    // Name the two compare registers and pulses.
    always_comb begin
        sup_cmp_q = cmp_q[0];
        hyp_cmp_q = cmp_q[1];
        sup_pulse = pulse[0];
        hyp_pulse = pulse[1];
    end

    tct_intr_regs #(.SOFT_W(SOFT_W), .TICK_BIT(TICK_BIT)) u_intr (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_wr  (wr_en && (wr_sel == SEL_SOFT)),
        .soft_set (wr_en && (wr_sel == SEL_SOFTSET)),
        .soft_clr (wr_en && (wr_sel == SEL_SOFTCLR)),
        .soft_val (wr_data[SOFT_W-1:0]),
        .hint_wr  (wr_en && (wr_sel == SEL_HINT)),
        .hint_val (wr_data[0]),
        .tick_set (hit[0] && !sup_cmp_q[CNT_W]),
        .hyp_set  (hit[1] && !hyp_cmp_q[CNT_W] && !halted),
        .softint  (softint),
        .hintp    (hintp)
    );

    // Read mux.
    always_comb begin
        case (rd_sel)
            SEL_COUNT:  rd_data = {1'b0, count_q};
            SEL_SUPCMP: rd_data = sup_cmp_q;
            SEL_HYPCMP: rd_data = hyp_cmp_q;
            SEL_SOFT:   rd_data = DW'(softint);
            SEL_HINT:   rd_data = DW'(hintp);
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tct_checker.sv
// Assertion checker for the tick compare timer, bound to the top module.
module tct_checker #(
    parameter int CNT_W  = 63,
    parameter int SOFT_W = 17,
    parameter int TICK_BIT = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              halted,
    input logic              wr_en,
    input logic [2:0]        wr_sel,
    input logic [CNT_W-1:0]  count_q,
    input logic [CNT_W:0]    sup_cmp_q,
    input logic [CNT_W:0]    hyp_cmp_q,
    input logic              sup_pulse,
    input logic              hyp_pulse,
    input logic [SOFT_W-1:0] softint,
    input logic              hintp
);
    logic soft_sw_set;
    logic hint_sw;
    always_comb soft_sw_set = wr_en && (wr_sel == 3'd3 || wr_sel == 3'd4);
    always_comb hint_sw     = wr_en && (wr_sel == 3'd6);

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && tick_en && !(wr_en && wr_sel == 3'd0) |=> count_q == $past(count_q) + 1'b1);

    a_r3_sup_single: assert property (@(posedge clk) disable iff (!rst_n)
        sup_pulse |=> !sup_pulse);

    a_r3_hyp_single: assert property (@(posedge clk) disable iff (!rst_n)
        hyp_pulse |=> !hyp_pulse);

    a_r6_tick_set: assert property (@(posedge clk) disable iff (!rst_n)
        sup_pulse && !$past(sup_cmp_q[CNT_W]) |-> softint[TICK_BIT]);

    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sup_pulse && $past(sup_cmp_q[CNT_W]) && !$past(softint[TICK_BIT]) && !$past(soft_sw_set)
        |-> !softint[TICK_BIT]);

    a_r7_halted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        hyp_pulse && $past(halted) && !$past(hintp) && !$past(hint_sw) |-> !hintp);
endmodule

bind tick_cmp_timer tct_checker #(.CNT_W(CNT_W), .SOFT_W(SOFT_W), .TICK_BIT(TICK_BIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .halted    (halted),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .count_q   (count_q),
    .sup_cmp_q (sup_cmp_q),
    .hyp_cmp_q (hyp_cmp_q),
    .sup_pulse (sup_pulse),
    .hyp_pulse (hyp_pulse),
    .softint   (softint),
    .hintp     (hintp)
);

// File: tb/sim_tick_cmp_timer.sv
`timescale 1ns/1ps
module sim_tick_cmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        halted = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [63:0] rd_data;
    logic        sup_pulse, hyp_pulse, hintp;
    logic [16:0] softint;

    int total = 0;
    int bad = 0;
    int ncyc = 0;
    bit done = 0;

    // expected state
    logic [62:0] m_cnt;
    logic [63:0] m_cmp [2];
    logic        m_arm [2];
    logic [16:0] m_soft;
    logic        m_hint;
    logic        m_pulse [2];

    always #4 clk = ~clk;

    tick_cmp_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .halted(halted),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .sup_pulse(sup_pulse), .hyp_pulse(hyp_pulse),
        .softint(softint), .hintp(hintp)
    );

    function automatic logic [63:0] exp_read(input logic [2:0] s);
        case (s)
            3'd0: return {1'b0, m_cnt};
            3'd1: return m_cmp[0];
            3'd2: return m_cmp[1];
            3'd3: return {47'b0, m_soft};
            3'd6: return {63'b0, m_hint};
            default: return 64'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = '0;
        for (int i = 0; i < 2; i++) begin
            m_cmp[i] = 64'h8000_0000_0000_0000;
            m_arm[i] = 1'b0;
            m_pulse[i] = 1'b0;
        end
        m_soft = '0;
        m_hint = 1'b0;
    endtask

    // One clock: drive inputs, predict, then compare at the next falling edge.
    task automatic cyc(input string tag, input bit we, input logic [2:0] sel,
                       input logic [63:0] d, input bit en, input bit hl);
        logic        hit [2];
        logic [62:0] n_cnt;
        logic [16:0] n_soft;
        logic        n_hint;
        wr_en = we; wr_sel = sel; wr_data = d; tick_en = en; halted = hl;
        rd_sel = 3'(ncyc % 8);
        for (int i = 0; i < 2; i++)
            hit[i] = m_arm[i] && (m_cnt == m_cmp[i][62:0]) && !(we && sel == 3'(i + 1));
        n_cnt = (we && sel == 3'd0) ? d[62:0] : (en ? m_cnt + 1'b1 : m_cnt);
        n_soft = m_soft;
        if (we && sel == 3'd3)      n_soft = d[16:0];
        else if (we && sel == 3'd4) n_soft = m_soft | d[16:0];
        else if (we && sel == 3'd5) n_soft = m_soft & ~d[16:0];
        if (hit[0] && !m_cmp[0][63]) n_soft[16] = 1'b1;
        n_hint = (we && sel == 3'd6) ? d[0] : m_hint;
        if (hit[1] && !m_cmp[1][63] && !hl) n_hint = 1'b1;
        for (int i = 0; i < 2; i++) begin
            m_pulse[i] = hit[i];
            if (we && sel == 3'(i + 1)) begin
                m_arm[i] = (d[62:0] > m_cnt);
                m_cmp[i] = d;
            end else if (hit[i]) begin
                m_arm[i] = 1'b0;
            end
        end
        m_cnt = n_cnt; m_soft = n_soft; m_hint = n_hint;
        @(posedge clk);
        @(negedge clk);
        ncyc++;
        chk(tag, "sup_pulse", 64'(sup_pulse), 64'(m_pulse[0]));
        chk(tag, "hyp_pulse", 64'(hyp_pulse), 64'(m_pulse[1]));
        chk(tag, "softint",   64'(softint),   64'(m_soft));
        chk(tag, "hintp",     64'(hintp),     64'(m_hint));
        chk(tag, "rd_data",   rd_data,        exp_read(rd_sel));
    endtask

    task automatic idle(input string tag, input int n, input bit en, input bit hl);
        for (int k = 0; k < n; k++) cyc(tag, 1'b0, 3'd0, 64'd0, en, hl);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen through every read select
        idle("R1", 8, 1'b0, 1'b0);
        // R2: load near the top, count across the wrap, then hold
        cyc("R2", 1'b1, 3'd0, 64'h7FFF_FFFF_FFFF_FFFD, 1'b1, 1'b0);
        idle("R2", 6, 1'b1, 1'b0);
        idle("R2", 3, 1'b0, 1'b0);
        // R3: arm ahead, match once; compare equal to count does not arm
        cyc("R3", 1'b1, 3'd0, 64'd100, 1'b0, 1'b0);
        cyc("R3", 1'b1, 3'd1, 64'd104, 1'b1, 1'b0);
        idle("R3", 8, 1'b1, 1'b0);
        cyc("R3", 1'b1, 3'd1, {1'b0, m_cnt}, 1'b1, 1'b0);
        idle("R3", 4, 1'b1, 1'b0);
        // R3: stalled counter at the match value pulses only once
        cyc("R3", 1'b1, 3'd2, {1'b0, m_cnt + 63'd2}, 1'b1, 1'b0);
        cyc("R3", 1'b0, 3'd0, 64'd0, 1'b1, 1'b0);
        idle("R3", 5, 1'b0, 1'b0);
        // R9: software writes, then clear of bit 16 racing a match
        cyc("R9", 1'b1, 3'd3, 64'h0_0005, 1'b0, 1'b0);
        cyc("R9", 1'b1, 3'd4, 64'h1_0100, 1'b0, 1'b0);
        cyc("R9", 1'b1, 3'd5, 64'h1_0001, 1'b0, 1'b0);
        cyc("R9", 1'b1, 3'd6, 64'd0, 1'b0, 1'b0);
        cyc("R9", 1'b1, 3'd1, {1'b0, m_cnt + 63'd1}, 1'b1, 1'b0);
        cyc("R9", 1'b1, 3'd4, 64'h1_0000, 1'b0, 1'b0);
        cyc("R9", 1'b1, 3'd5, 64'h1_0000, 1'b0, 1'b0);
        cyc("R9", 1'b1, 3'd1, {1'b0, m_cnt + 63'd1}, 1'b1, 1'b0);
        cyc("R9", 1'b1, 3'd5, 64'h1_FFFF, 1'b0, 1'b0);
        idle("R9", 3, 1'b0, 1'b0);
        cyc("R9", 1'b1, 3'd3, 64'd0, 1'b0, 1'b0);
        // R4: full 64-bit readback, top bit not compared
        cyc("R4", 1'b1, 3'd2, 64'hC000_0000_0000_0123, 1'b0, 1'b0);
        idle("R4", 8, 1'b0, 1'b0);
        // R5: disabled supervisor compare pulses but sets nothing
        cyc("R5", 1'b1, 3'd1, {1'b1, m_cnt + 63'd3}, 1'b1, 1'b0);
        idle("R5", 6, 1'b1, 1'b0);
        // R6: enabled supervisor compare sets bit 16
        cyc("R6", 1'b1, 3'd1, {1'b0, m_cnt + 63'd2}, 1'b1, 1'b0);
        idle("R6", 5, 1'b1, 1'b0);
        // R7: hypervisor match while halted, then while running
        cyc("R7", 1'b1, 3'd2, {1'b0, m_cnt + 63'd2}, 1'b1, 1'b1);
        idle("R7", 5, 1'b1, 1'b1);
        cyc("R7", 1'b1, 3'd2, {1'b0, m_cnt + 63'd2}, 1'b1, 1'b0);
        idle("R7", 5, 1'b1, 1'b0);
        // R8: rewrite in the match cycle cancels the old match
        cyc("R8", 1'b1, 3'd1, {1'b0, m_cnt + 63'd2}, 1'b1, 1'b0);
        cyc("R8", 1'b0, 3'd0, 64'd0, 1'b1, 1'b0);
        cyc("R8", 1'b1, 3'd1, {1'b0, m_cnt + 63'd40}, 1'b1, 1'b0);
        idle("R8", 6, 1'b1, 1'b0);
        // R10: every read select, including unused ones
        idle("R10", 16, 1'b0, 1'b0);
        // random mix
        for (int n = 0; n < 4000; n++) begin
            bit          we;
            logic [2:0]  s;
            we = ($urandom % 6) == 0;
            s = 3'($urandom % 7);
            v = {$urandom, $urandom};
            if (s == 3'd1 || s == 3'd2)
                v = {v[63] & v[62], m_cnt + 63'($urandom % 12)};
            if (s == 3'd0 && ($urandom % 4) != 0) we = 1'b0;
            cyc("R3", we, s, v, ($urandom % 4) != 0, ($urandom % 5) == 0);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule